// File: doc/BRIEF.md
# GPIO Expander Register Core

This block is the register and pin logic of an eight-bit general-purpose I/O expander. A controller reaches it through a plain register bus (two-bit register address, write strobe and data, read strobe and data) that stands in for the serial target engine in front of it. Four registers sit behind that bus: a direction register, a drive-value register, a read-inversion mask and a captured-input register. Together they set per-pin output enables and output levels, and they return the sampled pin levels to the controller.

Input pins pass through a two-flop synchroniser. A read of the input register returns the synchronised pins, XORed bit by bit with the inversion mask, and on the same clock edge it records the raw synchronised value as the captured snapshot. An active-low interrupt output goes low while any pin that is configured as an input differs from that snapshot. It is released by the next input read, or when the pins return to the captured levels. A one-bit strap picks the least significant bit of the seven-bit target address, so two expanders can share one bus.

Top module: `gpx_core`

## Requirements
- R1: After reset the drive register reads 0xFF, the inversion mask reads 0x00 and the direction register reads 0xFF (a 1 bit means input). So `pin_oe` is 0x00, `pin_out` is 0xFF, `irq_n` is 1 and the captured snapshot is 0x00.
- R2: A write to address 1 (drive), 2 (inversion mask) or 3 (direction) takes effect at that clock edge. The new value is returned by a read of the same address in the next cycle.
- R3: Address 0 (input) is read-only. A write to it leaves all three writable registers and the input read value unchanged.
- R4: `pin_oe[i]` is the inverse of direction bit i, and `pin_out` equals the drive register.
- R5: While `rd_en` is high with address 0, `rd_data` shows in the same cycle the synchronised pins XOR the inversion mask, where a mask bit of 1 inverts its pin. A pin change reaches this path two clock edges after it is applied. `rd_data` is 0 while `rd_en` is low.
- R6: A read of address 0 loads the synchronised pins into the snapshot at that edge. If the pins are stable, `irq_n` is 1 right after that edge.
- R7: `irq_n` goes low two clock edges after an input-configured pin changes away from the snapshot, and not after the first edge.
- R8: Pins whose direction bit is 0 (output) never pull `irq_n` low.
- R9: `irq_n` returns to 1 two edges after the pins return to the snapshot, without any read.
- R10: `target_addr` equals the upper six bits of the base address with `addr_sel` as bit 0 (0x20 or 0x21 by default).
- R11: Driving `rst_n` low during operation restores every R1 default, without a power cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Address strap, becomes target address bit 0 |
| target_addr | output | 7 | Decoded bus target address |
| reg_addr | input | 2 | Register index: 0 input, 1 drive, 2 inversion, 3 direction |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; a read of address 0 also captures |
| rd_data | output | 8 | Read data, combinational from the selected register |
| pin_in | input | 8 | Raw levels of the pins |
| pin_out | output | 8 | Drive values for the pins |
| pin_oe | output | 8 | Per-pin output enable, 1 = driving |
| irq_n | output | 1 | Active-low change interrupt (open-drain in the pad) |

## Verification
Register writes land at the strobe edge. The bench reads them back in the following cycle and samples `pin_out` and `pin_oe` one nanosecond after the next falling edge. Read data is combinational, so it is sampled one nanosecond after the read strobe is driven and before the capturing edge. A pin change is due at the read path and at `irq_n` exactly two rising edges later. The bench samples after one edge to confirm the interrupt is still high, then after the second edge to confirm it is low. The release of `irq_n` after an input read is sampled just after the capturing edge.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

   localparam int REG_AW = 2;

   typedef enum logic [REG_AW-1:0] {
      RA_INPUT    = 2'd0,
      RA_DRIVE    = 2'd1,
      RA_INVERT   = 2'd2,
      RA_DIR      = 2'd3
   } reg_addr_e;

endpackage

// File: rtl/gpx_sync.sv
// Multi-stage pin synchroniser; depth set by STAGES (minimum two).
module gpx_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("gpx_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("gpx_sync: WIDTH must be positive");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpx_regfile.sv
// Writable control registers: drive values, read inversion mask, direction.
module gpx_regfile
   import gpx_pkg::*;
#(
   parameter int               WIDTH     = 8,
   parameter logic [WIDTH-1:0] DRIVE_RST = '1,
   parameter logic [WIDTH-1:0] INV_RST   = '0,
   parameter logic [WIDTH-1:0] DIR_RST   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [WIDTH-1:0]  wr_data,
   output logic [WIDTH-1:0]  drive_q,
   output logic [WIDTH-1:0]  inv_q,
   output logic [WIDTH-1:0]  dir_q
);

   logic hit_drive, hit_inv, hit_dir;

   always_comb begin
      hit_drive = wr_en && (wr_addr == RA_DRIVE);
      hit_inv   = wr_en && (wr_addr == RA_INVERT);
      hit_dir   = wr_en && (wr_addr == RA_DIR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= DRIVE_RST;
      end else if (hit_drive) begin
         drive_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inv_q <= INV_RST;
      end else if (hit_inv) begin
         inv_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= DIR_RST;
      end else if (hit_dir) begin
         dir_q <= wr_data;
      end
   end

endmodule

// File: rtl/gpx_change_det.sv
// Input snapshot and change-detect interrupt.
module gpx_change_det #(
   parameter int WIDTH    = 8,
   parameter bit IRQ_FLOP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sync_in,
   input  logic [WIDTH-1:0] dir_q,
   input  logic             capture,
   output logic [WIDTH-1:0] cap_q,
   output logic             irq_n
);

   logic [WIDTH-1:0] mism;
   logic             any_mism;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
      end else if (capture) begin
         cap_q <= sync_in;
      end
   end

   always_comb begin
      mism     = (sync_in ^ cap_q) & dir_q;
      any_mism = |mism;
   end

   generate
      if (IRQ_FLOP) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b1;
            end else begin
               irq_q <= ~any_mism;
            end
         end
         assign irq_n = irq_q;
      end else begin : g_irq_comb
         assign irq_n = ~any_mism;
      end
   endgenerate

endmodule

// File: rtl/gpx_core.sv
// GPIO expander register core: register bus, pin control, change interrupt.
module gpx_core
   import gpx_pkg::*;
#(
   parameter int               WIDTH       = 8,
   parameter int               TADDR_W     = 7,
   parameter logic [TADDR_W-1:0] ADDR_BASE = 7'h20,
   parameter int               SYNC_STAGES = 2,
   parameter bit               IRQ_FLOP    = 1'b0,
   parameter logic [WIDTH-1:0] DRIVE_RST   = '1,
   parameter logic [WIDTH-1:0] INV_RST     = '0,
   parameter logic [WIDTH-1:0] DIR_RST     = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               addr_sel,
   output logic [TADDR_W-1:0] target_addr,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic               wr_en,
   input  logic [WIDTH-1:0]   wr_data,
   input  logic               rd_en,
   output logic [WIDTH-1:0]   rd_data,
   input  logic [WIDTH-1:0]   pin_in,
   output logic [WIDTH-1:0]   pin_out,
   output logic [WIDTH-1:0]   pin_oe,
   output logic               irq_n
);

   generate
      if (TADDR_W < 2) begin : g_bad_taddr
         $error("gpx_core: TADDR_W must be at least 2");
      end
      if (ADDR_BASE[0] != 1'b0) begin : g_bad_base
         $error("gpx_core: ADDR_BASE bit 0 must be zero, the strap owns it");
      end
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("gpx_core: WIDTH out of range");
      end
   endgenerate

   logic [WIDTH-1:0] sync_q;
   logic [WIDTH-1:0] cap_q;
   logic [WIDTH-1:0] drive_q;
   logic [WIDTH-1:0] inv_q;
   logic [WIDTH-1:0] dir_q;
   logic             in_capture;
   logic [WIDTH-1:0] rd_mux;

   gpx_sync #(
      .WIDTH  (WIDTH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (sync_q)
   );

   gpx_regfile #(
      .WIDTH     (WIDTH),
      .DRIVE_RST (DRIVE_RST),
      .INV_RST   (INV_RST),
      .DIR_RST   (DIR_RST)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (reg_addr),
      .wr_data (wr_data),
      .drive_q (drive_q),
      .inv_q   (inv_q),
      .dir_q   (dir_q)
   );

   assign in_capture = rd_en && (reg_addr == RA_INPUT);

   gpx_change_det #(
      .WIDTH    (WIDTH),
      .IRQ_FLOP (IRQ_FLOP)
   ) u_chg (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_in (sync_q),
      .dir_q   (dir_q),
      .capture (in_capture),
      .cap_q   (cap_q),
      .irq_n   (irq_n)
   );

   always_comb begin
      case (reg_addr)
         RA_INPUT:  rd_mux = sync_q ^ inv_q;
         RA_DRIVE:  rd_mux = drive_q;
         RA_INVERT: rd_mux = inv_q;
         default:   rd_mux = dir_q;
      endcase
      rd_data = rd_en ? rd_mux : '0;
   end

   assign pin_out     = drive_q;
   assign pin_oe      = ~dir_q;
   assign target_addr = {ADDR_BASE[TADDR_W-1:1], addr_sel};

endmodule

// File: rtl/gpx_core_chk.sv
// Property checker, bound into every gpx_core instance.
module gpx_core_chk #(
   parameter int WIDTH   = 8,
   parameter int TADDR_W = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               addr_sel,
   input logic [TADDR_W-1:0] target_addr,
   input logic [1:0]         reg_addr,
   input logic               wr_en,
   input logic [WIDTH-1:0]   wr_data,
   input logic               rd_en,
   input logic [WIDTH-1:0]   pin_out,
   input logic [WIDTH-1:0]   pin_oe,
   input logic               irq_n,
   input logic [WIDTH-1:0]   sync_q,
   input logic [WIDTH-1:0]   cap_q,
   input logic [WIDTH-1:0]   drive_q,
   input logic [WIDTH-1:0]   inv_q,
   input logic [WIDTH-1:0]   dir_q
);

   p_drive_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr == 2'd1) |=> (pin_out == $past(wr_data)));

   p_dir_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr == 2'd3) |=> (pin_oe == ~$past(wr_data)));

   p_input_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr == 2'd0) |=>
         ($stable(drive_q) && $stable(inv_q) && $stable(dir_q)));

   p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && reg_addr == 2'd0) |=> (cap_q == $past(sync_q)));

   p_outputs_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_q == '0 && $past(dir_q) == '0) |-> irq_n);

   always_comb begin
      if (rst_n) begin
         p_addr_strap_r10: assert (target_addr[0] == addr_sel);
      end
   end

endmodule

bind gpx_core gpx_core_chk #(
   .WIDTH   (WIDTH),
   .TADDR_W (TADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr_sel    (addr_sel),
   .target_addr (target_addr),
   .reg_addr    (reg_addr),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .rd_en       (rd_en),
   .pin_out     (pin_out),
   .pin_oe      (pin_oe),
   .irq_n       (irq_n),
   .sync_q      (sync_q),
   .cap_q       (cap_q),
   .drive_q     (drive_q),
   .inv_q       (inv_q),
   .dir_q       (dir_q)
);

// File: tb/gpx_core_test.sv
module gpx_core_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_sel = 1'b0;
   logic [6:0] target_addr;
   logic [1:0] reg_addr = 2'd0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [7:0] pin_in = 8'h00;
   logic [7:0] pin_out;
   logic [7:0] pin_oe;
   logic       irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpx_core uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_sel    (addr_sel),
      .target_addr (target_addr),
      .reg_addr    (reg_addr),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .rd_en       (rd_en),
      .rd_data     (rd_data),
      .pin_in      (pin_in),
      .pin_out     (pin_out),
      .pin_oe      (pin_oe),
      .irq_n       (irq_n)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // All tasks start just after a falling edge.
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      reg_addr = a; rd_en = 1'b1;
      #1 chk(tag, rd_data, exp);
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      edges(2);
      rst_n = 1'b1;
   endtask

   task automatic defaults(input string tag);
      #1;
      chk({tag, " pin_oe"}, pin_oe, 8'h00);
      chk({tag, " pin_out"}, pin_out, 8'hFF);
      chk({tag, " irq_n"}, {7'd0, irq_n}, 8'h01);
      rd(2'd1, 8'hFF, {tag, " drive"});
      rd(2'd2, 8'h00, {tag, " invert"});
      rd(2'd3, 8'hFF, {tag, " dir"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1 reset state
      defaults("R1");
      rd(2'd0, 8'h00, "R1 snapshot");

      // R10 strap decode
      addr_sel = 1'b0; #1 chk("R10 sel0", {1'b0, target_addr}, 8'h20);
      addr_sel = 1'b1; #1 chk("R10 sel1", {1'b0, target_addr}, 8'h21);
      addr_sel = 1'b0;
      @(negedge clk);

      // R2 / R4 exhaustive write-readback of each writable register
      for (int d = 0; d < 256; d++) begin
         wr(2'd1, 8'(d));
         #1 chk("R4 pin_out", pin_out, 8'(d));
         rd(2'd1, 8'(d), "R2 drive");
         wr(2'd2, 8'(d));
         rd(2'd2, 8'(d), "R2 invert");
         wr(2'd3, 8'(d));
         #1 chk("R4 pin_oe", pin_oe, ~8'(d));
         rd(2'd3, 8'(d), "R2 dir");
      end

      // R3 input register is read-only
      wr(2'd1, 8'h3C); wr(2'd2, 8'h00); wr(2'd3, 8'hFF);
      pin_in = 8'h96; edges(2);
      rd(2'd0, 8'h96, "R3 before");
      wr(2'd0, 8'h5A);
      rd(2'd1, 8'h3C, "R3 drive kept");
      rd(2'd2, 8'h00, "R3 invert kept");
      rd(2'd3, 8'hFF, "R3 dir kept");
      rd(2'd0, 8'h96, "R3 input kept");
      #1 chk("R3 pin_out", pin_out, 8'h3C);

      // R5 inversion sweep over all masks
      for (int p = 0; p < 256; p++) begin
         wr(2'd2, 8'(p));
         for (int k = 0; k < 3; k++) begin
            logic [7:0] pat;
            pat = (k == 0) ? 8'h00 : (k == 1) ? 8'hA5 : (8'(p) ^ 8'h3C);
            pin_in = pat;
            edges(2);
            rd(2'd0, pat ^ 8'(p), "R5 invert read");
         end
      end
      rd_en = 1'b0; reg_addr = 2'd0;
      #1 chk("R5 idle zero", rd_data, 8'h00);
      @(negedge clk);

      // R6..R9 per-pin change detection
      wr(2'd2, 8'h00); wr(2'd3, 8'hFF);
      for (int i = 0; i < 8; i++) begin
         logic [7:0] bit_m;
         bit_m = 8'(1 << i);
         pin_in = 8'h00; edges(2);
         rd(2'd0, 8'h00, "R6 base");
         #1 chk("R6 idle", {7'd0, irq_n}, 8'h01);
         pin_in = bit_m;
         edges(1);
         #1 chk("R7 one edge", {7'd0, irq_n}, 8'h01);
         edges(1);
         #1 chk("R7 two edges", {7'd0, irq_n}, 8'h00);
         pin_in = 8'h00;
         edges(2);
         #1 chk("R9 return", {7'd0, irq_n}, 8'h01);
         pin_in = bit_m;
         edges(2);
         #1 chk("R7 again", {7'd0, irq_n}, 8'h00);
         reg_addr = 2'd0; rd_en = 1'b1;
         #1 chk("R5 changed read", rd_data, bit_m);
         @(posedge clk); #1;
         chk("R6 cleared", {7'd0, irq_n}, 8'h01);
         @(negedge clk); rd_en = 1'b0;
         wr(2'd3, ~bit_m);
         pin_in = 8'h00;
         edges(2);
         #1 chk("R8 output pin", {7'd0, irq_n}, 8'h01);
         wr(2'd3, 8'hFF);
         #1 chk("R8 back to input", {7'd0, irq_n}, 8'h00);
         rd(2'd0, 8'h00, "R6 recapture");
      end

      // R11 reset during operation
      wr(2'd1, 8'h12); wr(2'd2, 8'h34); wr(2'd3, 8'h0F);
      pin_in = 8'h00;
      do_reset();
      defaults("R11");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule